// File: doc/BRIEF.md
# I2C Bit-Rate Parameter Search Engine

This block works out the clock settings for an I2C controller. It takes a source clock frequency and a target bit rate, both as 32-bit unsigned integers. For each candidate SCL half-period count it calculates a clock prescaler and the rate error that prescaler leaves. It returns the prescaler and the SCL high and low count fields of the candidate with the smallest error. The output fields are already in register format.

The block is sequential and is started by a single pulse. It copies its operands when it accepts the pulse and reports busy while it works. Each candidate goes through an iterative divider that produces one quotient bit per clock. The search may end early. A one-cycle done pulse marks the moment the outputs become valid. An error flag replaces the result when no usable prescaler exists.

Top module: `i2c_rate_search`

## Requirements
- R1: While reset is active, and after it is released, busy_o, done_o and err_o are 0, and prescale_o, scl_high_o and scl_low_o are 0.
- R2: In the idle state, a start_i pulse with a nonzero rate_i starts a search and raises busy_o on the next clock. The search uses the operands captured on that edge. While busy_o is high, start_i and any change to src_hz_i or rate_hz_i have no effect on the result or on the timing.
- R3: Candidates are tried in descending order, from 9 down to 2. Each tried candidate takes exactly 34 clocks. The done pulse comes 34×N clocks after the start edge, where N is the number of candidates tried.
- R4: For candidate c, the prescaler is floor(src / (rate × 2 × c)). Any value above 65536 is clamped to 65536. The products are exact and do not wrap at 32 bits.
- R5: The error of a candidate is src − rate × 2 × c × prescaler. A candidate becomes the best when its error is strictly smaller than the best error so far, or when the best error so far is zero. The first candidate is therefore always taken, and a tie keeps the earlier (larger) candidate.
- R6: The search stops after the current candidate when that candidate's error is zero or its clamped prescaler equals 65536. Otherwise it stops after candidate 2.
- R7: On success, err_o is 0. prescale_o is the best prescaler minus 1, and scl_high_o and scl_low_o both equal the best candidate minus 2.
- R8: done_o is high for exactly one clock. busy_o falls on that same edge.
- R9: A start with rate_i equal to 0 keeps busy_o low. It raises done_o and err_o on the next clock and clears all three fields.
- R10: If the best prescaler is 0, the done pulse comes with err_o = 1 and all three fields are cleared.
- R11: err_o, prescale_o, scl_high_o and scl_low_o change only on the edge that raises done_o. They hold their values until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; accepted only when idle |
| src_hz_i | input | 32 | Source clock frequency in Hz |
| rate_hz_i | input | 32 | Target bit rate in bit/s |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse: outputs are valid |
| err_o | output | 1 | Last search produced no usable prescaler |
| prescale_o | output | 16 | Best prescaler minus 1 |
| scl_high_o | output | 3 | SCL high count field: best candidate minus 2 |
| scl_low_o | output | 3 | SCL low count field: best candidate minus 2 |

## Verification
The bound checker checks the following properties on every clock:
- done_o is a single-cycle pulse, and busy_o ends exactly on it.
- The high and low fields are equal and lie within the candidate range.
- The error result carries cleared fields.
- The outputs hold between done pulses.
- A zero rate, or an accepted nonzero rate, gets the correct response on the next clock.

Some properties can only be shown by the bench's scenarios. These are the numeric prescaler and candidate choice, the tie rule, the two early exits, the 34-cycle cost of each candidate, and the fact that start and operand changes during a search are ignored. The bench compares each of these against a behavioural model on every clock, using both directed and pseudo-random operand pairs.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DIVIDE,
    ST_SCORE
  } rs_state_e;
endpackage

// File: rtl/i2c_rate_term.sv
// Divisor for one candidate: rate * 2 * cand, exact width
module i2c_rate_term #(
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned CAND_W = 4,
  parameter int unsigned DEN_W  = 37
) (
  input  logic [FREQ_W-1:0] rate_i,
  input  logic [CAND_W-1:0] cand_i,
  output logic [DEN_W-1:0]  den_o
);
  always_comb begin
    den_o = DEN_W'(rate_i) * DEN_W'({cand_i, 1'b0});
  end
endmodule

// File: rtl/i2c_rate_divider.sv
// Restoring divider, one quotient bit per clock
module i2c_rate_divider #(
  parameter int unsigned DVD_W = 32,
  parameter int unsigned DSR_W = 37
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DSR_W-1:0] divisor_i,
  output logic [DVD_W-1:0] quotient_o,
  output logic             last_o
);
  localparam int unsigned CNT_W = $clog2(DVD_W + 1);

  logic [DSR_W:0]   rem_q;
  logic [DVD_W-1:0] quo_q;
  logic [DSR_W-1:0] dsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DSR_W:0]   rem_shift;
  logic [DSR_W:0]   rem_trial;
  logic             fits;

  always_comb begin
    rem_shift = {rem_q[DSR_W-1:0], quo_q[DVD_W-1]};
    rem_trial = rem_shift - {1'b0, dsr_q};
    fits      = rem_shift >= {1'b0, dsr_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= dividend_i;
      dsr_q <= divisor_i;
      cnt_q <= CNT_W'(DVD_W);
    end else if (cnt_q != '0) begin
      rem_q <= fits ? rem_trial : rem_shift;
      quo_q <= {quo_q[DVD_W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign quotient_o = quo_q;
  assign last_o     = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/i2c_rate_score.sv
// Clamp, error and decision for one candidate
module i2c_rate_score #(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned DEN_W   = 37,
  parameter int unsigned PRE_W   = 17,
  parameter int unsigned PRE_MAX = 65536
) (
  input  logic [FREQ_W-1:0] src_i,
  input  logic [DEN_W-1:0]  den_i,
  input  logic [FREQ_W-1:0] quo_i,
  input  logic [FREQ_W-1:0] best_err_i,
  input  logic              cand_last_i,
  output logic [PRE_W-1:0]  pre_o,
  output logic [FREQ_W-1:0] err_o,
  output logic              take_o,
  output logic              stop_o
);
  localparam int unsigned PROD_W = DEN_W + PRE_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] diff;
  logic              clamped;

  always_comb begin
    clamped = quo_i > FREQ_W'(PRE_MAX);
    pre_o   = clamped ? PRE_W'(PRE_MAX) : quo_i[PRE_W-1:0];
    prod    = PROD_W'(den_i) * PROD_W'(pre_o);
    diff    = PROD_W'(src_i) - prod;
    err_o   = diff[FREQ_W-1:0];
    take_o  = (err_o < best_err_i) || (best_err_i == '0);
    stop_o  = (err_o == '0) || (pre_o >= PRE_W'(PRE_MAX)) || cand_last_i;
  end
endmodule

// File: rtl/i2c_rate_search.sv
module i2c_rate_search
  import i2c_rate_pkg::*;
#(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned CAND_HI = 9,
  parameter int unsigned CAND_LO = 2,
  parameter int unsigned PRE_MAX = 65536,
  localparam int unsigned PRE_OUT_W = $clog2(PRE_MAX),
  localparam int unsigned FIELD_W   = $clog2(CAND_HI - CAND_LO + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [FREQ_W-1:0]    src_hz_i,
  input  logic [FREQ_W-1:0]    rate_hz_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic [PRE_OUT_W-1:0] prescale_o,
  output logic [FIELD_W-1:0]   scl_high_o,
  output logic [FIELD_W-1:0]   scl_low_o
);
  localparam int unsigned CAND_W = $clog2(CAND_HI + 1);
  localparam int unsigned STEP_W = $clog2(2 * CAND_HI + 1);
  localparam int unsigned DEN_W  = FREQ_W + STEP_W;
  localparam int unsigned PRE_W  = $clog2(PRE_MAX + 1);

  rs_state_e         state_q;
  logic [CAND_W-1:0] cand_q;
  logic [FREQ_W-1:0] src_q;
  logic [FREQ_W-1:0] rate_q;
  logic [PRE_W-1:0]  best_pre_q;
  logic [CAND_W-1:0] best_cand_q;
  logic [FREQ_W-1:0] best_err_q;

  logic                 done_q;
  logic                 err_q;
  logic [PRE_OUT_W-1:0] pre_out_q;
  logic [FIELD_W-1:0]   high_q;
  logic [FIELD_W-1:0]   low_q;

  logic [DEN_W-1:0]  den_w;
  logic [FREQ_W-1:0] quo_w;
  logic              div_last;
  logic              div_load;
  logic [PRE_W-1:0]  sc_pre;
  logic [FREQ_W-1:0] sc_err;
  logic              sc_take;
  logic              sc_stop;
  logic              cand_last;
  logic [PRE_W-1:0]  fin_pre;
  logic [CAND_W-1:0] fin_cand;

  i2c_rate_term #(
    .FREQ_W(FREQ_W),
    .CAND_W(CAND_W),
    .DEN_W (DEN_W)
  ) u_term (
    .rate_i(rate_q),
    .cand_i(cand_q),
    .den_o (den_w)
  );

  assign div_load = (state_q == ST_LOAD);

  i2c_rate_divider #(
    .DVD_W(FREQ_W),
    .DSR_W(DEN_W)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (div_load),
    .dividend_i(src_q),
    .divisor_i (den_w),
    .quotient_o(quo_w),
    .last_o    (div_last)
  );

  assign cand_last = (cand_q == CAND_W'(CAND_LO));

  i2c_rate_score #(
    .FREQ_W (FREQ_W),
    .DEN_W  (DEN_W),
    .PRE_W  (PRE_W),
    .PRE_MAX(PRE_MAX)
  ) u_score (
    .src_i      (src_q),
    .den_i      (den_w),
    .quo_i      (quo_w),
    .best_err_i (best_err_q),
    .cand_last_i(cand_last),
    .pre_o      (sc_pre),
    .err_o      (sc_err),
    .take_o     (sc_take),
    .stop_o     (sc_stop)
  );

  always_comb begin
    fin_pre  = sc_take ? sc_pre : best_pre_q;
    fin_cand = sc_take ? cand_q : best_cand_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cand_q      <= CAND_W'(CAND_HI);
      src_q       <= '0;
      rate_q      <= '0;
      best_pre_q  <= '0;
      best_cand_q <= CAND_W'(CAND_HI);
      best_err_q  <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      pre_out_q   <= '0;
      high_q      <= '0;
      low_q       <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (rate_hz_i == '0) begin
              done_q    <= 1'b1;
              err_q     <= 1'b1;
              pre_out_q <= '0;
              high_q    <= '0;
              low_q     <= '0;
            end else begin
              src_q       <= src_hz_i;
              rate_q      <= rate_hz_i;
              cand_q      <= CAND_W'(CAND_HI);
              best_pre_q  <= '0;
              best_cand_q <= CAND_W'(CAND_HI);
              best_err_q  <= '0;
              state_q     <= ST_LOAD;
            end
          end
        end
        ST_LOAD: state_q <= ST_DIVIDE;
        ST_DIVIDE: begin
          if (div_last) state_q <= ST_SCORE;
        end
        ST_SCORE: begin
          if (sc_take) begin
            best_pre_q  <= sc_pre;
            best_cand_q <= cand_q;
            best_err_q  <= sc_err;
          end
          if (sc_stop) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            if (fin_pre == '0) begin
              err_q     <= 1'b1;
              pre_out_q <= '0;
              high_q    <= '0;
              low_q     <= '0;
            end else begin
              err_q     <= 1'b0;
              pre_out_q <= PRE_OUT_W'(fin_pre - 1'b1);
              high_q    <= FIELD_W'(fin_cand - CAND_W'(CAND_LO));
              low_q     <= FIELD_W'(fin_cand - CAND_W'(CAND_LO));
            end
          end else begin
            cand_q  <= cand_q - 1'b1;
            state_q <= ST_LOAD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign prescale_o = pre_out_q;
  assign scl_high_o = high_q;
  assign scl_low_o  = low_q;
endmodule

// File: rtl/i2c_rate_search_chk.sv
module i2c_rate_search_chk #(
  parameter int unsigned FREQ_W    = 32,
  parameter int unsigned PRE_OUT_W = 16,
  parameter int unsigned FIELD_W   = 3,
  parameter int unsigned CAND_SPAN = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [FREQ_W-1:0]    rate_hz_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 err_o,
  input logic [PRE_OUT_W-1:0] prescale_o,
  input logic [FIELD_W-1:0]   scl_high_o,
  input logic [FIELD_W-1:0]   scl_low_o
);
  AST_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && rate_hz_i != '0) |=> busy_o); // R2

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_IDLE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R8

  AST_FIELD_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (scl_high_o == scl_low_o && 32'(scl_high_o) <= CAND_SPAN)); // R7

  AST_ZERO_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && rate_hz_i == '0) |=> (done_o && err_o && !busy_o)); // R9

  AST_ERR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (prescale_o == '0 && scl_high_o == '0 && scl_low_o == '0)); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || ($stable(prescale_o) && $stable(err_o) &&
                            $stable(scl_high_o) && $stable(scl_low_o)))); // R11
endmodule

bind i2c_rate_search i2c_rate_search_chk #(
  .FREQ_W   (FREQ_W),
  .PRE_OUT_W(PRE_OUT_W),
  .FIELD_W  (FIELD_W),
  .CAND_SPAN(CAND_HI - CAND_LO)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .rate_hz_i (rate_hz_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .prescale_o(prescale_o),
  .scl_high_o(scl_high_o),
  .scl_low_o (scl_low_o)
);

// File: tb/test_i2c_rate_search.sv
`timescale 1ns/1ps
module test_i2c_rate_search;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] src_hz_i = '0;
  logic [31:0] rate_hz_i = '0;
  logic        busy_o, done_o, err_o;
  logic [15:0] prescale_o;
  logic [2:0]  scl_high_o, scl_low_o;

  int n_chk = 0;
  int n_bad = 0;

  bit        exp_err = 1'b0;
  int        exp_pre = 0;
  int        exp_fld = 0;

  always #5 clk_i = ~clk_i;

  i2c_rate_search i_i2c_rate_search (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .src_hz_i  (src_hz_i),
    .rate_hz_i (rate_hz_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .prescale_o(prescale_o),
    .scl_high_o(scl_high_o),
    .scl_low_o (scl_low_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference of the search
  task automatic model(input longint unsigned src, input longint unsigned rate,
                       output int n, output bit e, output int pre, output int fld);
    longint unsigned best_err, best_div, best_c, den, dv, er;
    best_err = 0; best_div = 0; best_c = 9; n = 0;
    for (int c = 9; c >= 2; c--) begin
      n++;
      den = rate * longint'(c) * 2;
      dv  = src / den;
      if (dv > 65536) dv = 65536;
      er  = src - den * dv;
      if (er < best_err || best_err == 0) begin
        best_err = er; best_div = dv; best_c = longint'(c);
      end
      if (er == 0 || dv >= 65536) break;
    end
    e   = (best_div == 0);
    pre = e ? 0 : int'(best_div - 1);
    fld = e ? 0 : int'(best_c - 2);
  endtask

  task automatic cmp_fields(input string req);
    chk(err_o == exp_err, {req, " err"}, longint'(err_o), longint'(exp_err));
    chk(int'(prescale_o) == exp_pre, {req, " prescale"}, longint'(prescale_o), longint'(exp_pre));
    chk(int'(scl_high_o) == exp_fld, {req, " high"}, longint'(scl_high_o), longint'(exp_fld));
    chk(int'(scl_low_o) == exp_fld, {req, " low"}, longint'(scl_low_o), longint'(exp_fld));
  endtask

  // One search, compared on every clock; meddle=1 pokes start and operands mid-run (R2)
  task automatic run(input logic [31:0] src, input logic [31:0] rate, input string req, input bit meddle);
    int n, pre, fld, lat;
    bit e;
    model(longint'(src), longint'(rate), n, e, pre, fld);
    lat = (rate == 0) ? 0 : 34 * n;
    @(negedge clk_i);
    start_i = 1'b1; src_hz_i = src; rate_hz_i = rate;
    for (int cyc = 0; cyc <= lat + 2; cyc++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (cyc == lat) begin
        exp_err = e; exp_pre = pre; exp_fld = fld;
      end
      chk(busy_o == (rate != 0 && cyc < lat), "R3 busy", longint'(busy_o), longint'(rate != 0 && cyc < lat));
      chk(done_o == (cyc == lat), "R8 done", longint'(done_o), longint'(cyc == lat));
      cmp_fields((cyc == lat) ? req : "R11 hold");
      if (meddle && cyc == 5) begin
        start_i = 1'b1; src_hz_i = 32'd12345; rate_hz_i = 32'd7;
      end
      if (meddle && cyc == 6) begin
        src_hz_i = 32'hFFFF_0000; rate_hz_i = 32'd0;
      end
    end
  endtask

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    // R1: reset values
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0, "R1 ctrl", longint'({busy_o, done_o}), 0);
    cmp_fields("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1 after release",
        longint'({busy_o, done_o, err_o}), 0);
    cmp_fields("R1");

    run(32'd12_000_000, 32'd100_000, "R6 zero-error exit", 1'b0);
    run(32'hFFFF_FFFF, 32'd1, "R4 clamp exit", 1'b0);
    run(32'd37, 32'd1, "R5 tie keeps earlier", 1'b0);
    run(32'd0, 32'd5, "R10 zero source", 1'b0);
    run(32'd10, 32'd1000, "R10 no prescaler", 1'b0);
    run(32'd0, 32'd0, "R9 zero rate", 1'b0);
    run(32'd1_000_003, 32'd100, "R7 full sweep", 1'b0);
    run(32'd48_000_000, 32'd400_000, "R2 start ignored", 1'b1);
    run(32'd50_000, 32'd0, "R9 zero rate again", 1'b0);
    run(32'd150_000_000, 32'd1_000_000, "R4 mid range", 1'b0);
    for (int i = 0; i < 12; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      src_hz_i = seed;
      seed = seed * 32'd1103515245 + 32'd12345;
      run(src_hz_i, (seed % 32'd600_000) + 32'd1, "R7 random", 1'b0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule